// File: doc/BRIEF.md
# Banked Register Address Decoder

This block sits between a host bus and a set of device registers. It turns one host access into a read or write strobe for a single register. It also picks the read data that goes back to the host. The registers sit in two banks of sixteen register indices each. Bank 1 holds the registers used to bring the device up (initialization). Bank 0 holds the registers used while the device runs (operation). One bit of a mode register, which this block holds itself, chooses the bank. The mode register sits at the same index in both banks, so the host can always reach it and switch banks.

There are two bus modes. In demultiplexed mode the register index comes from four separate address pins. In multiplexed mode a shared address/data bus carries a byte address. The block captures that address while the address-latch strobe is high and holds it after the strobe falls. Only even byte addresses are meaningful: address bits 4 to 1 give the index and bit 0 is ignored. In both modes the bank bit and the index together form a 5-bit slot number, {bank, index}. Each slot has its own strobe line.

Top module: `bank_reg_decoder`

## Requirements
- R1: In demultiplexed mode (`muxMode`=0), the index is `addrIn`. An access strikes slot {bank, `addrIn`}.
- R2: A bank value of 1 (bit 5 of the mode register) reaches slots 16 to 31, the initialization set. A bank value of 0 reaches slots 0 to 15, the operational set. No strobe ever falls outside the current bank's half.
- R3: Index 15 is the mode register in either bank. A read of index 15 returns its value. A write of index 15 loads it from `busIn`. An access to index 15 raises no external strobe.
- R4: A write to the mode register changes the bank from the next clock onward. The access that writes it is still decoded with the old bank.
- R5: In multiplexed mode (`muxMode`=1), `busIn` is captured on every clock edge where `ale` is high and is held while `ale` is low. The index is bits 4 to 1 of the held byte and bit 0 is ignored. An access in the same cycle as `ale` uses the previously held address.
- R6: A slot whose bit in `USED_MASK` is 0 reads as zero and raises no strobe on a read or a write. The default mask is 0x03FF0FFF.
- R7: Reset loads the mode register with 0x20 (bank 1) and clears the held multiplexed address.
- R8: At most one bit of `rdStrobe`, and at most one bit of `wrStrobe`, is high in a cycle. Strobes rise only with `rdEn`/`wrEn`. If both enables are high, only the write is performed.
- R9: During a read of a used slot, `rdData` equals that slot's byte of `regRdData`. Outside a read, `rdData` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| muxMode | input | 1 | 1 = multiplexed bus, 0 = demultiplexed |
| ale | input | 1 | Address-latch strobe (multiplexed mode) |
| addrIn | input | 4 | Register index (demultiplexed mode) |
| busIn | input | 8 | Address phase (multiplexed mode) and write data |
| rdEn | input | 1 | Read access this cycle |
| wrEn | input | 1 | Write access this cycle |
| regRdData | input | 256 | Read value of every slot, slot s at bits 8s+7..8s |
| rdData | output | 8 | Read data returned to host |
| rdStrobe | output | 32 | Per-slot read strobes |
| wrStrobe | output | 32 | Per-slot write strobes |
| modeReg | output | 8 | Mode register contents, bank bit at bit 5 |

## Verification
The assertions check on every cycle that the strobes are at most one-hot and stay quiet without an enable. They also check that strobes stay inside the current bank's half and never touch unused slots or the mode index. They further check that unused reads return zero and that a decoded mode write lands one clock later. Only the bench's scenarios can show the rest. That covers which slot an address reaches in each bus mode, the hold of the multiplexed address across the strobe's fall, and the odd-address case. It also covers the bank switch taking effect exactly one access later, the read data selected for each slot, and write priority over read.

// File: rtl/bank_dec_pkg.sv
package bank_dec_pkg;
  localparam int DATA_W    = 8;
  localparam int IDX_W     = 4;
  localparam int SLOT_W    = IDX_W + 1;
  localparam int NUM_SLOTS = 1 << SLOT_W;

  // strobes from control to datapath
  typedef struct packed {
    logic              rdHit;   // read of a used external slot
    logic              wrHit;   // write of a used external slot
    logic              modeRd;  // read of the mode register
    logic              modeWr;  // write of the mode register
    logic [SLOT_W-1:0] slot;    // {bank, index}
  } decStrobe_t;
endpackage

// File: rtl/bank_dec_ctrl.sv
module bank_dec_ctrl
  import bank_dec_pkg::*;
#(
  parameter int                   MODE_IDX  = 15,
  parameter logic [NUM_SLOTS-1:0] USED_MASK = 32'h03FF_0FFF
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 muxMode,
  input  logic                 ale,
  input  logic [IDX_W-1:0]     addrIn,
  input  logic [DATA_W-1:0]    busIn,
  input  logic                 rdEn,
  input  logic                 wrEn,
  input  logic                 bankSel,
  output decStrobe_t           ctl,
  output logic [NUM_SLOTS-1:0] rdStrobe,
  output logic [NUM_SLOTS-1:0] wrStrobe
);
  logic [DATA_W-1:0] addrHeld;
  logic [IDX_W-1:0]  idx;
  logic              isMode;
  logic              isUsed;
  logic              doWrite;
  logic              doRead;

  // multiplexed address capture: follows the bus while ale is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)    addrHeld <= '0;
    else if (ale) addrHeld <= busIn;
  end

  always_comb begin
    idx     = muxMode ? addrHeld[IDX_W:1] : addrIn;
    isMode  = (idx == IDX_W'(MODE_IDX));
    doWrite = wrEn;
    doRead  = rdEn && !wrEn;
    ctl.slot   = {bankSel, idx};
    isUsed     = USED_MASK[ctl.slot] && !isMode;
    ctl.wrHit  = doWrite && isUsed;
    ctl.rdHit  = doRead && isUsed;
    ctl.modeWr = doWrite && isMode;
    ctl.modeRd = doRead && isMode;
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign wrStrobe[g] = ctl.wrHit && (ctl.slot == SLOT_W'(g));
    assign rdStrobe[g] = ctl.rdHit && (ctl.slot == SLOT_W'(g));
  end
endmodule

// File: rtl/bank_dec_dp.sv
module bank_dec_dp
  import bank_dec_pkg::*;
#(
  parameter int BANK_BIT = 5
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  decStrobe_t                  ctl,
  input  logic [DATA_W-1:0]           busIn,
  input  logic [NUM_SLOTS*DATA_W-1:0] regRdData,
  output logic [DATA_W-1:0]           rdData,
  output logic [DATA_W-1:0]           modeReg,
  output logic                        bankSel
);
  localparam logic [DATA_W-1:0] MODE_RST = DATA_W'(1) << BANK_BIT;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           modeReg <= MODE_RST;
    else if (ctl.modeWr) modeReg <= busIn;
  end

  assign bankSel = modeReg[BANK_BIT];

  always_comb begin
    if (ctl.modeRd)     rdData = modeReg;
    else if (ctl.rdHit) rdData = regRdData[ctl.slot*DATA_W +: DATA_W];
    else                rdData = '0;
  end
endmodule

// File: rtl/bank_reg_decoder.sv
module bank_reg_decoder
  import bank_dec_pkg::*;
#(
  parameter int                   MODE_IDX  = 15,
  parameter int                   BANK_BIT  = 5,
  parameter logic [NUM_SLOTS-1:0] USED_MASK = 32'h03FF_0FFF
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        muxMode,
  input  logic                        ale,
  input  logic [IDX_W-1:0]            addrIn,
  input  logic [DATA_W-1:0]           busIn,
  input  logic                        rdEn,
  input  logic                        wrEn,
  input  logic [NUM_SLOTS*DATA_W-1:0] regRdData,
  output logic [DATA_W-1:0]           rdData,
  output logic [NUM_SLOTS-1:0]        rdStrobe,
  output logic [NUM_SLOTS-1:0]        wrStrobe,
  output logic [DATA_W-1:0]           modeReg
);
  decStrobe_t ctlStrobe;
  logic       bankSel;

  bank_dec_ctrl #(.MODE_IDX(MODE_IDX), .USED_MASK(USED_MASK)) i_ctrl (
    .clk(clk), .rstN(rstN), .muxMode(muxMode), .ale(ale), .addrIn(addrIn),
    .busIn(busIn), .rdEn(rdEn), .wrEn(wrEn), .bankSel(bankSel),
    .ctl(ctlStrobe), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe)
  );

  bank_dec_dp #(.BANK_BIT(BANK_BIT)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctlStrobe), .busIn(busIn),
    .regRdData(regRdData), .rdData(rdData), .modeReg(modeReg), .bankSel(bankSel)
  );
endmodule

// File: rtl/bank_dec_chk.sv
module bank_dec_chk
  import bank_dec_pkg::*;
#(
  parameter int                   MODE_IDX  = 15,
  parameter int                   BANK_BIT  = 5,
  parameter logic [NUM_SLOTS-1:0] USED_MASK = 32'h03FF_0FFF
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 rdEn,
  input logic                 wrEn,
  input logic [DATA_W-1:0]    busIn,
  input logic [DATA_W-1:0]    rdData,
  input logic [NUM_SLOTS-1:0] rdStrobe,
  input logic [NUM_SLOTS-1:0] wrStrobe,
  input logic [DATA_W-1:0]    modeReg,
  input decStrobe_t           ctlStrobe
);
  localparam int HALF = NUM_SLOTS / 2;
  localparam logic [NUM_SLOTS-1:0] LOW_HALF  = {{HALF{1'b0}}, {HALF{1'b1}}};
  localparam logic [NUM_SLOTS-1:0] MODE_SLOTS =
      (NUM_SLOTS'(1) << MODE_IDX) | (NUM_SLOTS'(1) << (MODE_IDX + HALF));

  logic [NUM_SLOTS-1:0] bankHalf;
  assign bankHalf = modeReg[BANK_BIT] ? ~LOW_HALF : LOW_HALF;

  // R8
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rdStrobe) && $onehot0(wrStrobe));
  // R8
  strobe_needs_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((!rdEn || wrEn) |-> rdStrobe == '0) and (!wrEn |-> wrStrobe == '0));
  // R2
  bank_half_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((rdStrobe | wrStrobe) & ~bankHalf) == '0);
  // R3
  mode_no_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((rdStrobe | wrStrobe) & MODE_SLOTS) == '0);
  // R6
  unused_no_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((rdStrobe | wrStrobe) & ~USED_MASK) == '0);
  // R6
  unused_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && !ctlStrobe.rdHit && !ctlStrobe.modeRd) |-> rdData == '0);
  // R4
  mode_write_next_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctlStrobe.modeWr |=> modeReg == $past(busIn));
  // R7
  reset_value_chk: assert property (@(posedge clk)
    !rstN |=> modeReg == (DATA_W'(1) << BANK_BIT));
endmodule

bind bank_reg_decoder bank_dec_chk #(
  .MODE_IDX(MODE_IDX), .BANK_BIT(BANK_BIT), .USED_MASK(USED_MASK)
) i_chk (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .busIn(busIn),
  .rdData(rdData), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe),
  .modeReg(modeReg), .ctlStrobe(ctlStrobe)
);

// File: tb/test_bank_reg_decoder.sv
`timescale 1ns/1ps
module test_bank_reg_decoder;
  localparam int NS = 32;
  localparam logic [31:0] USED = 32'h03FF_0FFF;

  logic clk = 0;
  logic rstN = 0;
  logic muxMode = 0, ale = 0, rdEn = 0, wrEn = 0;
  logic [3:0] addrIn = 0;
  logic [7:0] busIn = 0;
  logic [NS*8-1:0] regRdData;
  logic [7:0] rdData, modeReg;
  logic [NS-1:0] rdStrobe, wrStrobe;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] modeM = 8'h20;
  logic [7:0] heldM = 8'h00;

  always #4 clk = ~clk;

  bank_reg_decoder i_bank_reg_decoder (
    .clk(clk), .rstN(rstN), .muxMode(muxMode), .ale(ale), .addrIn(addrIn),
    .busIn(busIn), .rdEn(rdEn), .wrEn(wrEn), .regRdData(regRdData),
    .rdData(rdData), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe), .modeReg(modeReg)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // compare at the falling edge, then advance the model at the rising edge
  task automatic step(string tag);
    int idx, slot;
    bit isMode, used, rd, wr;
    logic [31:0] expWr, expRd;
    logic [7:0] expData;
    @(negedge clk);
    idx    = muxMode ? int'(heldM[4:1]) : int'(addrIn);
    slot   = modeM[5] * 16 + idx;
    isMode = (idx == 15);
    used   = USED[slot] && !isMode;
    wr     = wrEn;
    rd     = rdEn && !wrEn;
    expWr  = (wr && used) ? (32'd1 << slot) : 32'd0;
    expRd  = (rd && used) ? (32'd1 << slot) : 32'd0;
    expData = !rd ? 8'h00 : isMode ? modeM : used ? regRdData[slot*8 +: 8] : 8'h00;
    check(tag, "wrStrobe", wrStrobe, expWr);
    check(tag, "rdStrobe", rdStrobe, expRd);
    check(tag, "rdData", {24'd0, rdData}, {24'd0, expData});
    check(tag, "modeReg", {24'd0, modeReg}, {24'd0, modeM});
    @(posedge clk);
    if (rstN) begin
      if (ale) heldM = busIn;
      if (wr && isMode) modeM = busIn;
    end
    #1;
  endtask

  task automatic access(string tag, bit mx, logic [3:0] a, bit r, bit w, logic [7:0] d);
    muxMode = mx; addrIn = a; rdEn = r; wrEn = w; busIn = d; ale = 0;
    step(tag);
    rdEn = 0; wrEn = 0;
  endtask

  task automatic latchAddr(string tag, logic [7:0] a);
    muxMode = 1; ale = 1; busIn = a; rdEn = 0; wrEn = 0;
    step(tag);
    ale = 0; busIn = 8'h00;
  endtask

  initial begin
    for (int s = 0; s < NS; s++) regRdData[s*8 +: 8] = 8'hA0 | 8'(s);
    // R7 reset state
    step("R7");
    step("R7");
    @(negedge clk); rstN = 1;
    @(posedge clk); #1;
    check("R7", "reset bank", {31'd0, modeReg[5]}, 32'd1);
    access("R7", 0, 4'd15, 1, 0, 8'h00);
    // R1 / R2 / R9 bank 1 demux sweep
    for (int i = 0; i < 16; i++) access("R1", 0, 4'(i), 0, 1, 8'h11);
    for (int i = 0; i < 16; i++) access("R9", 0, 4'(i), 1, 0, 8'h00);
    // R6 unused slots in bank 1
    access("R6", 0, 4'd12, 1, 0, 8'h00);
    access("R6", 0, 4'd12, 0, 1, 8'h33);
    // R4 switch to bank 0; write decoded with old bank then new bank next
    access("R4", 0, 4'd15, 0, 1, 8'h00);
    check("R4", "bank after write", {24'd0, modeReg}, 32'h00);
    access("R2", 0, 4'd3, 0, 1, 8'h44);
    for (int i = 0; i < 16; i++) access("R2", 0, 4'(i), 1, 0, 8'h00);
    access("R6", 0, 4'd13, 0, 1, 8'h55);
    // R3 mode register reachable from bank 0
    access("R3", 0, 4'd15, 1, 0, 8'h00);
    access("R3", 0, 4'd15, 0, 1, 8'h2C);
    access("R3", 0, 4'd15, 1, 0, 8'h00);
    // R8 write wins over read
    access("R8", 0, 4'd2, 1, 1, 8'h66);
    access("R8", 0, 4'd2, 0, 0, 8'h00);
    // R5 multiplexed mode: even, odd, hold, same-cycle ale
    latchAddr("R5", 8'h06);
    access("R5", 1, 4'd0, 0, 1, 8'h77);
    access("R5", 1, 4'd9, 1, 0, 8'h00);
    latchAddr("R5", 8'h07);
    access("R5", 1, 4'd0, 1, 0, 8'h00);
    latchAddr("R5", 8'h1E);
    access("R5", 1, 4'd0, 0, 1, 8'h00);
    access("R5", 1, 4'd0, 1, 0, 8'h00);
    muxMode = 1; ale = 1; busIn = 8'h08; rdEn = 1; step("R5");
    ale = 0; step("R5"); rdEn = 0;
    // mixed random traffic
    for (int n = 0; n < 600; n++) begin
      muxMode = 1'($urandom);
      ale     = ($urandom % 4) == 0;
      addrIn  = 4'($urandom);
      busIn   = 8'($urandom);
      wrEn    = ($urandom % 3) == 0;
      rdEn    = ($urandom % 2) == 0;
      step("R1");
    end
    rdEn = 0; wrEn = 0; ale = 0;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule